// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Sequencer

This block owns the clock-enable pin of an SDRAM device. While the memory controller has nothing to do and automatic power-down is enabled, it pulls the clock-enable low so the device sits in power-down. When a refresh, a data access or a command execution is requested, it raises the clock-enable first. Only then does it tell the main sequencer, through a ready output, that the command may go out. After the sequencer reports that the operation is complete, the clock-enable falls again.

An advanced-timing option moves every clock-enable edge one clock earlier. In that mode the pin rises combinationally in the same cycle as the request and falls in the cycle right after completion. Request strobes are single-cycle pulses. A request that arrives while ready is already high is absorbed into the operation in progress. The main sequencer is expected to issue one operation per ready window.

Top module: `sdram_cke_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with both options low, cke_o is 1 and ready_o is 0.
- R2: With auto_pd_i held low, cke_o is 1 in every cycle after the first. A request seen with the pin already high raises ready_o in the next cycle.
- R3: With auto_pd_i high, adv_cke_en_i low and no operation in progress, cke_o is 0 from the second idle cycle onward.
- R4: In normal timing, from power-down (cke_o low), a pulse on any one of refresh_req_i, access_req_i or cmd_req_i has two effects. It raises cke_o one cycle after the request cycle, and it raises ready_o two cycles after it.
- R5: ready_o stays 1 until a cycle with op_done_i high. If no request accompanies that completion, ready_o is 0 in the next cycle.
- R6: In normal timing with auto_pd_i high, cke_o stays 1 for the cycle after the completion cycle and is 0 in the cycle after that.
- R7: With adv_cke_en_i high, a request makes cke_o 1 in the same cycle and ready_o 1 in the next. After a completion without a request, cke_o is 0 in the very next cycle.
- R8: A request that arrives in the completion cycle, or in the cycle after it, keeps cke_o at 1 with no low cycle. It makes ready_o 1 in the following cycle.
- R9: ready_o is never 1 while cke_o is 0.
- R10: A request that arrives while ready_o is already 1 and op_done_i is 0 is absorbed. The next completion still leads to power-down along the R6 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_pd_i | input | 1 | Enables automatic power-down while idle |
| adv_cke_en_i | input | 1 | Moves every clock-enable edge one cycle earlier |
| refresh_req_i | input | 1 | Single-cycle refresh request |
| access_req_i | input | 1 | Single-cycle memory access request |
| cmd_req_i | input | 1 | Single-cycle command execution request |
| op_done_i | input | 1 | Single-cycle completion strobe from the main sequencer |
| cke_o | output | 1 | SDRAM clock-enable |
| ready_o | output | 1 | The requested command may be issued |

## Verification
In normal timing, cke_o follows a request by one edge and ready_o follows it by two. The fall of cke_o comes two edges after completion. In advanced timing, cke_o responds in the request cycle itself, ready_o one edge later, and the fall of cke_o one edge after completion. The bench drives every input just after a falling edge and samples both outputs one time unit later, well before the next rising edge. The combinational advanced-mode path and the registered paths are therefore both seen in the cycle they are due. Each sample is compared with a cycle model kept in the bench, and directed sequences also compare against hand-counted literal values at each of these offsets.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_PD     = 2'd0,
    ST_WAKE        = 2'd1,
    ST_ACTIVE      = 2'd2,
    ST_SLEEP_PEND  = 2'd3
  } cke_state_e;

  localparam int unsigned NUM_REQ_SRC = 3;

endpackage

// File: rtl/sdram_cke_req_merge.sv
module sdram_cke_req_merge #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] req_vec_i,
  output logic             any_req_o
);

  logic [N_SRC:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | req_vec_i[g];
  end

  assign any_req_o = chain[N_SRC];

endmodule

// File: rtl/sdram_cke_fsm.sv
module sdram_cke_fsm
  import sdram_cke_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_req_i,
  input  logic       op_done_i,
  input  logic       auto_pd_i,
  input  logic       adv_i,
  input  logic       cke_lvl_q_i,
  output cke_state_e state_q_o,
  output cke_state_e state_d_o
);

  cke_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_PD: begin
        // skip the wake cycle when the pin is already high or leads by a cycle
        if (any_req_i) state_d = (adv_i || cke_lvl_q_i) ? ST_ACTIVE : ST_WAKE;
      end
      ST_WAKE: state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (op_done_i) begin
          if (any_req_i)      state_d = ST_ACTIVE;
          else if (auto_pd_i) state_d = ST_SLEEP_PEND;
          else                state_d = ST_IDLE_PD;
        end
      end
      ST_SLEEP_PEND: state_d = any_req_i ? ST_ACTIVE : ST_IDLE_PD;
      default:       state_d = ST_IDLE_PD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE_PD;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/sdram_cke_drive.sv
module sdram_cke_drive
  import sdram_cke_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cke_state_e state_d_i,
  input  logic       auto_pd_i,
  input  logic       adv_i,
  output logic       cke_lvl_q_o,
  output logic       cke_o
);

  logic cke_d, cke_q;

  assign cke_d = !((state_d_i == ST_IDLE_PD) && auto_pd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= RESET_LEVEL;
    else         cke_q <= cke_d;
  end

  // advanced timing presents the next level one cycle ahead
  assign cke_o       = adv_i ? cke_d : cke_q;
  assign cke_lvl_q_o = cke_q;

endmodule

// File: rtl/sdram_cke_seq.sv
module sdram_cke_seq
  import sdram_cke_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_pd_i,
  input  logic adv_cke_en_i,
  input  logic refresh_req_i,
  input  logic access_req_i,
  input  logic cmd_req_i,
  input  logic op_done_i,
  output logic cke_o,
  output logic ready_o
);

  logic [NUM_REQ_SRC-1:0] req_vec;
  logic                   any_req;
  logic                   cke_lvl_q;
  cke_state_e             state_q, state_d;

  assign req_vec = {cmd_req_i, access_req_i, refresh_req_i};

  sdram_cke_req_merge #(
    .N_SRC (NUM_REQ_SRC)
  ) u_merge (
    .req_vec_i (req_vec),
    .any_req_o (any_req)
  );

  sdram_cke_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_req_i   (any_req),
    .op_done_i   (op_done_i),
    .auto_pd_i   (auto_pd_i),
    .adv_i       (adv_cke_en_i),
    .cke_lvl_q_i (cke_lvl_q),
    .state_q_o   (state_q),
    .state_d_o   (state_d)
  );

  sdram_cke_drive #(
    .RESET_LEVEL (1'b1)
  ) u_drive (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_d_i   (state_d),
    .auto_pd_i   (auto_pd_i),
    .adv_i       (adv_cke_en_i),
    .cke_lvl_q_o (cke_lvl_q),
    .cke_o       (cke_o)
  );

  assign ready_o = (state_q == ST_ACTIVE);

endmodule

// File: rtl/sdram_cke_seq_chk.sv
module sdram_cke_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_pd_i,
  input logic adv_cke_en_i,
  input logic refresh_req_i,
  input logic access_req_i,
  input logic cmd_req_i,
  input logic op_done_i,
  input logic cke_o,
  input logic ready_o
);

  logic any_req;
  assign any_req = refresh_req_i | access_req_i | cmd_req_i;

  assert_pd_off_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_pd_i && $past(!auto_pd_i)) |-> cke_o);

  assert_ready_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !op_done_i) |=> ready_o);

  assert_ready_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && op_done_i && !any_req) |=> !ready_o);

  assert_adv_same_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_cke_en_i && any_req) |-> cke_o);

  assert_no_low_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && op_done_i && any_req) |=> (cke_o && ready_o));

  assert_ready_needs_cke_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cke_o);

endmodule

bind sdram_cke_seq sdram_cke_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .auto_pd_i     (auto_pd_i),
  .adv_cke_en_i  (adv_cke_en_i),
  .refresh_req_i (refresh_req_i),
  .access_req_i  (access_req_i),
  .cmd_req_i     (cmd_req_i),
  .op_done_i     (op_done_i),
  .cke_o         (cke_o),
  .ready_o       (ready_o)
);

// File: tb/tb_sdram_cke_seq.sv
module tb_sdram_cke_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int P_IDLE = 0, P_WAKE = 1, P_READY = 2, P_WIND = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic auto_pd, adv_cke, refresh_req, access_req, cmd_req, op_done;
  logic cke_o, ready_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  int   m_ph;
  logic m_cke_q;
  logic s_cke, s_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cke_seq dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .auto_pd_i     (auto_pd),
    .adv_cke_en_i  (adv_cke),
    .refresh_req_i (refresh_req),
    .access_req_i  (access_req),
    .cmd_req_i     (cmd_req),
    .op_done_i     (op_done),
    .cke_o         (cke_o),
    .ready_o       (ready_o)
  );

  function automatic int model_next(int ph, logic rq, logic dn, logic pd, logic ad, logic ckq);
    case (ph)
      P_IDLE:  return rq ? ((ad || ckq) ? P_READY : P_WAKE) : P_IDLE;
      P_WAKE:  return P_READY;
      P_READY: return !dn ? P_READY : (rq ? P_READY : (pd ? P_WIND : P_IDLE));
      default: return rq ? P_READY : P_IDLE;
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s cke/ready act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic lit(input string tag, input logic e_cke, input logic e_rdy);
    check(tag, {s_cke, s_rdy}, {e_cke, e_rdy});
  endtask

  task automatic step(input logic [2:0] rq, input logic dn, input logic pd, input logic ad,
                      input string tag);
    int   nxt;
    logic any, cke_d, e_cke, e_rdy;
    @(negedge clk);
    refresh_req = rq[0]; access_req = rq[1]; cmd_req = rq[2];
    op_done = dn; auto_pd = pd; adv_cke = ad;
    #1;
    any   = |rq;
    nxt   = model_next(m_ph, any, dn, pd, ad, m_cke_q);
    cke_d = !((nxt == P_IDLE) && pd);
    e_cke = ad ? cke_d : m_cke_q;
    e_rdy = (m_ph == P_READY);
    s_cke = cke_o;
    s_rdy = ready_o;
    check(tag, {s_cke, s_rdy}, {e_cke, e_rdy});
    m_ph    = nxt;
    m_cke_q = cke_d;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic pd_r, ad_r;
    logic [2:0] rq_r;
    logic dn_r;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0;
    auto_pd = 0; adv_cke = 0; refresh_req = 0; access_req = 0; cmd_req = 0; op_done = 0;
    m_ph = P_IDLE; m_cke_q = 1'b1;
    repeat (3) @(negedge clk);
    #1; s_cke = cke_o; s_rdy = ready_o;
    lit("R1 in reset", 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(3'b000, 0, 0, 0, "R1"); lit("R1", 1, 0);

    // normal timing, auto power-down on
    step(3'b000, 0, 1, 0, "R3"); lit("R3", 1, 0);
    step(3'b000, 0, 1, 0, "R3"); lit("R3", 0, 0);
    step(3'b001, 0, 1, 0, "R4"); lit("R4 refresh", 0, 0);
    step(3'b000, 0, 1, 0, "R4"); lit("R4", 1, 0);
    step(3'b000, 0, 1, 0, "R4"); lit("R4", 1, 1);
    step(3'b010, 0, 1, 0, "R10"); lit("R10", 1, 1);
    step(3'b000, 0, 1, 0, "R5"); lit("R5", 1, 1);
    step(3'b000, 1, 1, 0, "R5"); lit("R5", 1, 1);
    step(3'b000, 0, 1, 0, "R6"); lit("R6", 1, 0);
    step(3'b000, 0, 1, 0, "R6"); lit("R6 R10", 0, 0);
    step(3'b010, 0, 1, 0, "R4"); lit("R4 access", 0, 0);
    step(3'b000, 0, 1, 0, "R4"); lit("R4", 1, 0);
    step(3'b000, 0, 1, 0, "R4"); lit("R4", 1, 1);
    step(3'b100, 1, 1, 0, "R8"); lit("R8 done+req", 1, 1);
    step(3'b000, 0, 1, 0, "R8"); lit("R8", 1, 1);
    step(3'b000, 1, 1, 0, "R8"); lit("R8", 1, 1);
    step(3'b001, 0, 1, 0, "R8"); lit("R8 wind-down req", 1, 0);
    step(3'b000, 0, 1, 0, "R8"); lit("R8", 1, 1);
    step(3'b000, 1, 1, 0, "R6"); lit("R6", 1, 1);
    step(3'b000, 0, 1, 0, "R6"); lit("R6", 1, 0);
    step(3'b000, 0, 1, 0, "R6"); lit("R6", 0, 0);

    // advanced timing
    step(3'b100, 0, 1, 1, "R7"); lit("R7 cmd", 1, 0);
    step(3'b000, 0, 1, 1, "R7"); lit("R7", 1, 1);
    step(3'b000, 1, 1, 1, "R7"); lit("R7", 1, 1);
    step(3'b000, 0, 1, 1, "R7"); lit("R7", 0, 0);

    // auto power-down off
    step(3'b000, 0, 0, 0, "R2");
    step(3'b000, 0, 0, 0, "R2"); lit("R2", 1, 0);
    step(3'b001, 0, 0, 0, "R2"); lit("R2", 1, 0);
    step(3'b000, 0, 0, 0, "R2"); lit("R2", 1, 1);
    step(3'b000, 1, 0, 0, "R2"); lit("R2", 1, 1);
    step(3'b000, 0, 0, 0, "R2"); lit("R2", 1, 0);

    // random traffic against the cycle model
    pd_r = 1'b1; ad_r = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) pd_r = ~pd_r;
      if ($urandom % 80 == 0) ad_r = ~ad_r;
      rq_r = ($urandom % 6 == 0) ? (3'b001 << ($urandom % 3)) : 3'b000;
      dn_r = ($urandom % 3 == 0);
      step(rq_r, dn_r, pd_r, ad_r, "R9 random");
      if (s_rdy && !s_cke) check("R9", {s_cke, s_rdy}, 2'b11);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule